// File: doc/BRIEF.md
# Register-Programmed Transfer Launcher

This block lets software set up and start one bus-master transaction through a small bank of byte-addressable registers. Software fills in a local address, a remote address, a byte count, a lane mask and a control byte that picks the direction and the lock and burst options. It then starts the transaction by writing a fixed key byte to a dedicated start location. The block presents one request on a plain request/acknowledge master port, holds every request field steady until the acknowledge arrives, and reports its progress through busy and done flags.

The register port is 32 bits wide with four byte enables. A 2-bit word select picks one of four words, which gives a 4-bit byte offset of `{word_sel, lane}`. Byte lane `i` of a word is `wdata[8*i+7:8*i]`. The byte map is:

- 0x0: control
- 0x1: status
- 0x4..0x7: local address, with 0x4 the least significant byte
- 0x8..0xB: remote address, with 0x8 the least significant byte
- 0xC..0xD: length, with 0xC the low byte
- 0xE: lane mask
- 0xF: start key

Offsets 0x2 and 0x3 read as zero. The start byte 0xF also reads as zero. The block does not move any data itself.

Top module: `xfer_master_ctl`

## Requirements
- R1: A register write updates only the byte lanes whose enable is set. A read returns the addressed word on `reg_rdata` one clock after `reg_rd_en` is sampled.
- R2: Control bits are numbered from the most significant bit of byte 0x0. Bit 0 (`wdata[7]`) is read request, bit 1 (`wdata[6]`) is write request, bit 2 (`wdata[5]`) is lock and bit 3 (`wdata[4]`) is burst. These drive `mst_rd`, `mst_wr`, `mst_lock` and `mst_burst`. Bits 4..7 (`wdata[3:0]`) are spare and read back as written.
- R3: The status byte at 0x1 reads as `{done, busy, 6'b0}`, so done is bit 0 (MSB-first) and busy is bit 1. Writes to the status byte have no effect on it.
- R4: A transfer starts only when byte 0xF is written with the value 0x0A. Any other value written there starts nothing.
- R5: A start write is ignored, and busy stays low, when the read and write request bits are both set or both clear.
- R6: After an accepted start write, busy is high on the next cycle. `mst_req` rises one cycle later and stays high until `mst_ack` is sampled with it. On that edge, `mst_req` and busy fall and done rises.
- R7: An accepted start clears done. Start writes made while busy are ignored, and no second request follows.
- R8: `mst_len` (17 bits) carries the byte count. A length register of 0 gives 65536; any other value N gives N.
- R9: `mst_be` carries the lane-mask register for a single-beat request and 0xFF when burst is set.
- R10: While `mst_req` is high and `mst_ack` is low, the addresses, direction, lock, burst, length and lane mask on the master port stay unchanged, even if software rewrites the registers.
- R11: After reset, every register reads zero and busy, done and `mst_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_word_sel | input | 2 | Word select (byte offset bits 3:2) |
| reg_be | input | 4 | Byte-lane enables for writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer acknowledged |
| mst_req | output | 1 | Master request |
| mst_ack | input | 1 | Completion acknowledge |
| mst_rd | output | 1 | Read direction |
| mst_wr | output | 1 | Write direction |
| mst_lock | output | 1 | Bus lock flag |
| mst_burst | output | 1 | Burst flag |
| mst_remote_addr | output | 32 | Remote (bus-side) address |
| mst_local_addr | output | 32 | Local address |
| mst_len | output | 17 | Byte count, 1 to 65536 |
| mst_be | output | 8 | Byte enables |

## Verification
The assertions assume that `mst_ack` is meaningful only while `mst_req` is high, and that the responder does not acknowledge in the same cycle the request rises. The bench therefore raises `mst_ack` for exactly one cycle, always several cycles after it sees `mst_req`. During that wait, the bench rewrites the registers and checks that the request fields do not change. Register writes and start keys are driven at the falling edge, away from the sampling edge. The bench also makes start attempts that are illegal or made while busy, so the ignore paths are exercised.

// File: rtl/xm_pkg.sv
package xm_pkg;
  localparam int REG_DW  = 32;
  localparam int ADDR_W  = 32;
  localparam int LEN_W   = 16;
  localparam int BE_W    = 8;
  localparam int NBYTES  = 16;
  localparam int CNT_W   = LEN_W + 1;

  localparam logic [1:0] W_CTRL   = 2'd0;
  localparam logic [1:0] W_LOCAL  = 2'd1;
  localparam logic [1:0] W_REMOTE = 2'd2;
  localparam logic [1:0] W_MISC   = 2'd3;

  // storage present per byte offset (offset 1 is status, 2/3 reserved, 15 is the key)
  localparam logic [NBYTES-1:0] HAS_STORE = 16'h7FF1;

  typedef enum logic [1:0] {ST_IDLE, ST_LAUNCH, ST_WAIT} xm_state_t;
endpackage

// File: rtl/xm_regbank.sv
module xm_regbank
  import xm_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [1:0]          word_sel,
  input  logic [3:0]          be,
  input  logic [REG_DW-1:0]   wdata,
  input  logic [7:0]          status_byte,
  output logic [REG_DW-1:0]   rdata,
  output logic [7:0]          ctrl_q,
  output logic [ADDR_W-1:0]   local_q,
  output logic [ADDR_W-1:0]   remote_q,
  output logic [LEN_W-1:0]    len_q,
  output logic [BE_W-1:0]     lanes_q
);
  logic [7:0] byte_q [NBYTES];
  logic [7:0] view_b [NBYTES];

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    if (HAS_STORE[i]) begin : g_store
      always_ff @(posedge clk) begin
        if (rst)
          byte_q[i] <= 8'h00;
        else if (wr_en && word_sel == 2'(i / 4) && be[i % 4])
          byte_q[i] <= wdata[8*(i%4) +: 8];
      end
    end else begin : g_none
      assign byte_q[i] = 8'h00;
    end
    if (i == 1) begin : g_stat
      assign view_b[i] = status_byte;
    end else begin : g_plain
      assign view_b[i] = byte_q[i];
    end
  end

  assign ctrl_q   = byte_q[0];
  assign local_q  = {byte_q[7],  byte_q[6],  byte_q[5], byte_q[4]};
  assign remote_q = {byte_q[11], byte_q[10], byte_q[9], byte_q[8]};
  assign len_q    = {byte_q[13], byte_q[12]};
  assign lanes_q  = byte_q[14];

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en)
      rdata <= {view_b[{word_sel, 2'd3}], view_b[{word_sel, 2'd2}],
                view_b[{word_sel, 2'd1}], view_b[{word_sel, 2'd0}]};
  end
endmodule

// File: rtl/xm_seq.sv
module xm_seq
  import xm_pkg::*;
#(
  parameter logic [7:0] GO_KEY = 8'h0A
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          word_sel,
  input  logic [3:0]          be,
  input  logic [REG_DW-1:0]   wdata,
  input  logic [7:0]          ctrl_q,
  input  logic [ADDR_W-1:0]   local_q,
  input  logic [ADDR_W-1:0]   remote_q,
  input  logic [LEN_W-1:0]    len_q,
  input  logic [BE_W-1:0]     lanes_q,
  input  logic                mst_ack,
  output logic                go_ok,
  output logic                busy,
  output logic                done,
  output logic                mst_req,
  output logic                mst_rd,
  output logic                mst_wr,
  output logic                mst_lock,
  output logic                mst_burst,
  output logic [ADDR_W-1:0]   mst_remote_addr,
  output logic [ADDR_W-1:0]   mst_local_addr,
  output logic [CNT_W-1:0]    mst_len,
  output logic [BE_W-1:0]     mst_be
);
  xm_state_t state;
  logic      key_hit, dir_ok;

  // MSB-first numbering: bit0 = ctrl_q[7] (read), bit1 = ctrl_q[6] (write)
  assign key_hit = wr_en && word_sel == W_MISC && be[3] && wdata[31:24] == GO_KEY;
  assign dir_ok  = ctrl_q[7] ^ ctrl_q[6];
  assign go_ok   = key_hit && dir_ok && state == ST_IDLE;

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_IDLE;
      busy            <= 1'b0;
      done            <= 1'b0;
      mst_req         <= 1'b0;
      mst_rd          <= 1'b0;
      mst_wr          <= 1'b0;
      mst_lock        <= 1'b0;
      mst_burst       <= 1'b0;
      mst_remote_addr <= '0;
      mst_local_addr  <= '0;
      mst_len         <= '0;
      mst_be          <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (go_ok) begin
          state <= ST_LAUNCH;
          busy  <= 1'b1;
          done  <= 1'b0;
        end
        ST_LAUNCH: begin
          state           <= ST_WAIT;
          mst_req         <= 1'b1;
          mst_rd          <= ctrl_q[7];
          mst_wr          <= ctrl_q[6];
          mst_lock        <= ctrl_q[5];
          mst_burst       <= ctrl_q[4];
          mst_remote_addr <= remote_q;
          mst_local_addr  <= local_q;
          mst_len         <= (len_q == '0) ? CNT_W'(1) << LEN_W : CNT_W'(len_q);
          mst_be          <= ctrl_q[4] ? {BE_W{1'b1}} : lanes_q;
        end
        ST_WAIT: if (mst_ack) begin
          state   <= ST_IDLE;
          mst_req <= 1'b0;
          busy    <= 1'b0;
          done    <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xfer_master_ctl.sv
module xfer_master_ctl
  import xm_pkg::*;
#(
  parameter logic [7:0] GO_KEY = 8'h0A
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr_en,
  input  logic               reg_rd_en,
  input  logic [1:0]         reg_word_sel,
  input  logic [3:0]         reg_be,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               busy,
  output logic               done,
  output logic               mst_req,
  input  logic               mst_ack,
  output logic               mst_rd,
  output logic               mst_wr,
  output logic               mst_lock,
  output logic               mst_burst,
  output logic [31:0]        mst_remote_addr,
  output logic [31:0]        mst_local_addr,
  output logic [16:0]        mst_len,
  output logic [7:0]         mst_be
);
  logic [7:0]        ctrl_q, lanes_q;
  logic [ADDR_W-1:0] local_q, remote_q;
  logic [LEN_W-1:0]  len_q;
  logic              go_ok_w;

  xm_regbank u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .word_sel(reg_word_sel), .be(reg_be), .wdata(reg_wdata),
    .status_byte({done, busy, 6'b0}), .rdata(reg_rdata),
    .ctrl_q(ctrl_q), .local_q(local_q), .remote_q(remote_q),
    .len_q(len_q), .lanes_q(lanes_q)
  );

  xm_seq #(.GO_KEY(GO_KEY)) u_seq (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .word_sel(reg_word_sel),
    .be(reg_be), .wdata(reg_wdata), .ctrl_q(ctrl_q), .local_q(local_q),
    .remote_q(remote_q), .len_q(len_q), .lanes_q(lanes_q),
    .mst_ack(mst_ack), .go_ok(go_ok_w), .busy(busy), .done(done),
    .mst_req(mst_req), .mst_rd(mst_rd), .mst_wr(mst_wr),
    .mst_lock(mst_lock), .mst_burst(mst_burst),
    .mst_remote_addr(mst_remote_addr), .mst_local_addr(mst_local_addr),
    .mst_len(mst_len), .mst_be(mst_be)
  );
endmodule

// File: rtl/xm_checker.sv
module xm_checker (
  input logic        clk,
  input logic        rst,
  input logic        go_ok,
  input logic        busy,
  input logic        done,
  input logic        mst_req,
  input logic        mst_ack,
  input logic        mst_rd,
  input logic        mst_wr,
  input logic        mst_lock,
  input logic        mst_burst,
  input logic [31:0] mst_remote_addr,
  input logic [31:0] mst_local_addr,
  input logic [16:0] mst_len,
  input logic [7:0]  mst_be
);
  a_r6_busy_after_go: assert property (@(posedge clk) disable iff (rst)
    go_ok |=> busy && !done && !mst_req);

  a_r6_req_follows_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> mst_req);

  a_r6_req_holds: assert property (@(posedge clk) disable iff (rst)
    mst_req && !mst_ack |=> mst_req && busy);

  a_r6_done_on_ack: assert property (@(posedge clk) disable iff (rst)
    mst_req && mst_ack |=> done && !busy && !mst_req);

  a_r7_busy_ignores_go: assert property (@(posedge clk) disable iff (rst)
    busy && !(mst_req && mst_ack) |=> busy && !done);

  a_r3_not_both: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  a_r10_fields_stable: assert property (@(posedge clk) disable iff (rst)
    mst_req && !mst_ack |=> $stable(mst_remote_addr) && $stable(mst_local_addr)
      && $stable(mst_len) && $stable(mst_be) && $stable(mst_rd) && $stable(mst_wr)
      && $stable(mst_lock) && $stable(mst_burst));

  a_r5_one_direction: assert property (@(posedge clk) disable iff (rst)
    mst_req |-> $countones({mst_rd, mst_wr}) == 1);

  a_r8_len_nonzero: assert property (@(posedge clk) disable iff (rst)
    mst_req |-> mst_len != 17'd0 && mst_len <= 17'h10000);

  a_r9_burst_lanes: assert property (@(posedge clk) disable iff (rst)
    mst_req && mst_burst |-> mst_be == 8'hFF);
endmodule

bind xfer_master_ctl xm_checker u_chk (
  .clk(clk), .rst(rst), .go_ok(go_ok_w), .busy(busy), .done(done),
  .mst_req(mst_req), .mst_ack(mst_ack), .mst_rd(mst_rd), .mst_wr(mst_wr),
  .mst_lock(mst_lock), .mst_burst(mst_burst),
  .mst_remote_addr(mst_remote_addr), .mst_local_addr(mst_local_addr),
  .mst_len(mst_len), .mst_be(mst_be)
);

// File: tb/xfer_master_ctl_bench.sv
module xfer_master_ctl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0, mst_ack = 1'b0;
  logic [1:0]  reg_word_sel = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, mst_remote_addr, mst_local_addr;
  logic        busy, done, mst_req, mst_rd, mst_wr, mst_lock, mst_burst;
  logic [16:0] mst_len;
  logic [7:0]  mst_be;

  int n_chk = 0, n_fail = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  xfer_master_ctl u_xfer_master_ctl (.*);

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [15:0] len;
    logic [7:0]  lanes;
    logic [31:0] remote;
    logic [3:0]  flags;   // {rd, wr, lock, burst}
    logic [16:0] exp_len;
    logic [7:0]  exp_be;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{8'h40, 16'h0004, 8'hF0, 32'h0000_1000, 4'b0100, 17'd4,      8'hF0},
    '{8'h80, 16'h0000, 8'h0F, 32'h8000_0040, 4'b1000, 17'h10000,  8'h0F},
    '{8'h90, 16'h0020, 8'h01, 32'h1234_5678, 4'b1001, 17'h00020,  8'hFF},
    '{8'h6F, 16'hFFFF, 8'h3C, 32'hDEAD_BEE0, 4'b0110, 17'h0FFFF,  8'h3C}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] ws, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_word_sel = ws; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_be = '0;
  endtask

  task automatic rd(input logic [1:0] ws, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_word_sel = ws;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic go(input logic [7:0] key);
    wr(2'd3, 4'b1000, {key, 24'h0});
  endtask

  task automatic ack_once();
    @(negedge clk); mst_ack = 1'b1;
    @(negedge clk); mst_ack = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    chk(!busy && !done && !mst_req, "R11 flags", {busy, done, mst_req}, 0);
    rd(2'd0, rv); chk(rv == 0, "R11 word0", rv, 0);
    rd(2'd3, rv); chk(rv == 0, "R11 word3", rv, 0);

    // R1 byte-lane writes
    wr(2'd1, 4'b1111, 32'h1122_3344);
    wr(2'd1, 4'b0100, 32'h00AA_0000);
    rd(2'd1, rv); chk(rv == 32'h11AA_3344, "R1 lane merge", rv, 32'h11AA_3344);

    // R2/R3 spare readback, status and reserved lanes not writable
    wr(2'd0, 4'b1111, 32'hFFFF_FF6F);
    rd(2'd0, rv); chk(rv == 32'h0000_006F, "R2 R3 ctrl/status", rv, 32'h6F);

    // R4 wrong key
    wr(2'd0, 4'b0001, 32'h40);
    go(8'h0B);
    repeat (2) @(negedge clk);
    chk(!busy && !mst_req, "R4 bad key", {busy, mst_req}, 0);

    // R5 both and neither direction bits
    wr(2'd0, 4'b0001, 32'hC0); go(8'h0A);
    chk(!busy, "R5 both bits", busy, 0);
    wr(2'd0, 4'b0001, 32'h00); go(8'h0A);
    repeat (2) @(negedge clk);
    chk(!busy && !mst_req, "R5 no bits", {busy, mst_req}, 0);

    // vector table: R6 R8 R9 R10 R2
    for (int i = 0; i < 4; i++) begin
      logic [31:0] loc;
      loc = VECS[i].remote ^ 32'hFFFF_0000;
      wr(2'd0, 4'b0001, {24'h0, VECS[i].ctrl});
      wr(2'd1, 4'b1111, loc);
      wr(2'd2, 4'b1111, VECS[i].remote);
      wr(2'd3, 4'b0111, {8'h00, VECS[i].lanes, VECS[i].len});
      go(8'h0A);
      chk(busy && !mst_req, "R6 busy first", {busy, mst_req}, 2'b10);
      @(negedge clk);
      chk(mst_req, "R6 req second", mst_req, 1);
      chk({mst_rd, mst_wr, mst_lock, mst_burst} == VECS[i].flags, "R2 flags",
          {mst_rd, mst_wr, mst_lock, mst_burst}, VECS[i].flags);
      chk(mst_remote_addr == VECS[i].remote && mst_local_addr == loc, "R6 addrs",
          mst_remote_addr, VECS[i].remote);
      chk(mst_len == VECS[i].exp_len, "R8 length", mst_len, VECS[i].exp_len);
      chk(mst_be == VECS[i].exp_be, "R9 lanes", mst_be, VECS[i].exp_be);
      wr(2'd2, 4'b1111, 32'h5555_5555);
      wr(2'd3, 4'b0111, 32'h0000_0001);
      chk(mst_req && mst_remote_addr == VECS[i].remote && mst_len == VECS[i].exp_len,
          "R10 stable", mst_remote_addr, VECS[i].remote);
      ack_once();
      chk(!mst_req && !busy && done, "R6 complete", {mst_req, busy, done}, 3'b001);
    end

    // R3 status readback with done
    rd(2'd0, rv); chk(rv[15:8] == 8'h80, "R3 done bit", rv[15:8], 8'h80);

    // R7 done cleared by go, go while busy ignored
    wr(2'd0, 4'b0001, 32'h40);
    go(8'h0A);
    chk(busy && !done, "R7 done cleared", {busy, done}, 2'b10);
    rd(2'd0, rv); chk(rv[15:8] == 8'h40, "R3 busy bit", rv[15:8], 8'h40);
    go(8'h0A);
    ack_once();
    repeat (3) @(negedge clk);
    chk(!busy && done && !mst_req, "R7 no restart", {busy, done, mst_req}, 3'b010);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule